// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Engine

This block converts parallel characters to and from an asynchronous serial line. One character on the wire is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. A 16x oversampling tick from a separate baud generator paces both directions, so one bit period is 16 ticks.

On the transmit side, a holding register accepts a character from the host and passes it to a shift register that drives the line. On the receive side, a deserialiser samples the line at mid-bit and places each completed character in a receive holding register. Four sticky error flags report overrun, parity error, framing error and received break, and a single status-read strobe clears them. A break-control input forces the line low. A loopback input feeds the transmitter straight into the receiver while the external output rests at the idle level.

Top module: `uart_char_core`

## Requirements
- R1: `wordLen` picks the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data goes least significant bit first, between a low start bit and high stop bit(s), and each bit lasts 16 `tick16` pulses. Received data bits above the word length read as 0.
- R2: With `parityEn`=1 and `stickPar`=0, a parity bit follows the data. With `evenSel`=1 it makes the count of ones over data plus parity even. With `evenSel`=0 it makes that count odd.
- R3: With `parityEn`=1 and `stickPar`=1, the parity bit is a constant: 0 when `evenSel`=1 and 1 when `evenSel`=0. The receiver checks the incoming parity bit against that same constant.
- R4: With `twoStop`=1 the transmitter sends two stop bits. With `twoStop`=0 it sends one. The receiver checks only the first stop bit.
- R5: While `breakCtl`=1 and `loopEn`=0, `serOut` stays low.
- R6: `thrEmpty` is 1 when the holding register is empty. `txEmpty` is 1 only when the holding register and the shift register are both empty. A `txWrite` pulse while the holding register is full is ignored.
- R7: `dataReady` sets when a received character lands in the receive holding register (`rxData`) and clears on `rxRead`.
- R8: If a character completes while `dataReady` is 1 and no `rxRead` comes in that cycle, `overrunErr` sets and the new character is discarded; `rxData` keeps the older character.
- R9: `parityErr` sets on a parity mismatch, and `frameErr` sets when the first stop bit is sampled low on a character that is not a break. In both cases the character is still stored. All four error flags stay set until a `statRead` pulse. A new error that arrives in the same cycle as `statRead` wins.
- R10: If the line stays low for a whole character, through the stop position, `breakInt` sets, `frameErr` does not set, and no character is stored. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: The receiver treats a low pulse shorter than half a bit as a glitch and drops it. No character results and no flag sets.
- R12: With `loopEn`=1 the transmit stream, including any break, drives the receiver. `serOut` stays high and `serIn` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wordLen | input | 2 | Data bit count select (0..3 means 5..8 bits) |
| twoStop | input | 1 | 1 selects two transmitted stop bits |
| parityEn | input | 1 | Enables the parity bit |
| evenSel | input | 1 | Even parity when 1, odd when 0; also picks the stick constant |
| stickPar | input | 1 | Replaces computed parity with a constant |
| breakCtl | input | 1 | Forces the transmit line low |
| loopEn | input | 1 | Internal loopback from transmitter to receiver |
| txData | input | 8 | Character to transmit |
| txWrite | input | 1 | Loads `txData` into the holding register |
| rxRead | input | 1 | Consumes the received character |
| statRead | input | 1 | Clears the sticky error flags |
| serIn | input | 1 | Serial receive line |
| serOut | output | 1 | Serial transmit line |
| rxData | output | 8 | Received character |
| dataReady | output | 1 | Received character is available |
| thrEmpty | output | 1 | Transmit holding register is empty |
| txEmpty | output | 1 | Holding and shift registers are both empty |
| overrunErr | output | 1 | Sticky overrun flag |
| parityErr | output | 1 | Sticky parity error flag |
| frameErr | output | 1 | Sticky framing error flag |
| breakInt | output | 1 | Sticky received-break flag |

## Verification
The receiver is driven with frames at every word length, with data whose bits above the word length are set. It also gets frames with even, odd and both stick parity constants, each sent once with the correct parity bit and once with a wrong one, so a mask error can be told apart from a parity polarity error. On the transmit side, decoded frames show bit order and parity value, and the gap between back-to-back start edges shows one stop bit versus two. A held-low line, a short low pulse, a low stop bit and two unread characters cover the separate cases of break, glitch, framing error and overrun. Loopback is run with `serIn` held low, which shows that the receiver listens only to the internal path.

// File: rtl/uart_char_pkg.sv
package uart_char_pkg;
  localparam int MAX_DATA = 8;
  localparam int MIN_DATA = 5;
  localparam int IDX_W = $clog2(MAX_DATA);

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP, PH_WAITHI
  } phase_e;

  typedef struct packed {
    logic             txLoad;
    logic             txBusy;
    phase_e           txPhase;
    logic [IDX_W-1:0] txBitIdx;
    logic             rxClear;
    logic             rxDataSample;
    logic [IDX_W-1:0] rxBitIdx;
    logic             rxParSample;
    logic             rxStopSample;
    logic             rxBreak;
  } strobes_t;

  // parity bit for the active data bits; stick mode yields the constant
  function automatic logic parityOf(input logic [MAX_DATA-1:0] d,
                                    input logic [1:0] wl,
                                    input logic evenSel,
                                    input logic stick);
    logic [MAX_DATA-1:0] mask;
    mask = {MAX_DATA{1'b1}} >> (2'd3 - wl);
    if (stick) return ~evenSel;
    return evenSel ? ^(d & mask) : ~^(d & mask);
  endfunction
endpackage

// File: rtl/uart_char_ctrl.sv
module uart_char_ctrl
  import uart_char_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [1:0] wordLen,
  input  logic       twoStop,
  input  logic       parityEn,
  input  logic       thrFull,
  input  logic       rxLine,
  input  logic       rxAllZero,
  output strobes_t   strobes
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(TICKS_PER_BIT / 2 - 1);

  phase_e           txPh, rxPh;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [IDX_W-1:0] txIdx, rxIdx;
  logic             txSecondStop;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = IDX_W'(MIN_DATA - 1) + IDX_W'(wordLen);

  logic txBitEnd, rxBitEnd;
  assign txBitEnd = tick16 && (txCnt == LAST);
  assign rxBitEnd = tick16 && (rxCnt == LAST);

  // transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPh <= PH_IDLE;
      txCnt <= '0;
      txIdx <= '0;
      txSecondStop <= 1'b0;
    end else if (txPh == PH_IDLE) begin
      if (thrFull) begin
        txPh <= PH_START;
        txCnt <= '0;
      end
    end else if (tick16) begin
      if (txCnt != LAST) begin
        txCnt <= txCnt + 1'b1;
      end else begin
        txCnt <= '0;
        case (txPh)
          PH_START: begin
            txPh <= PH_DATA;
            txIdx <= '0;
          end
          PH_DATA: begin
            if (txIdx == lastIdx) begin
              txPh <= parityEn ? PH_PARITY : PH_STOP;
              txSecondStop <= 1'b0;
            end else begin
              txIdx <= txIdx + 1'b1;
            end
          end
          PH_PARITY: begin
            txPh <= PH_STOP;
            txSecondStop <= 1'b0;
          end
          PH_STOP: begin
            if (twoStop && !txSecondStop) txSecondStop <= 1'b1;
            else txPh <= PH_IDLE;
          end
          default: txPh <= PH_IDLE;
        endcase
      end
    end
  end

  // receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh <= PH_IDLE;
      rxCnt <= '0;
      rxIdx <= '0;
    end else begin
      case (rxPh)
        PH_IDLE: begin
          if (tick16 && !rxLine) begin
            rxPh <= PH_START;
            rxCnt <= '0;
          end
        end
        PH_WAITHI: if (rxLine) rxPh <= PH_IDLE;
        PH_START: begin
          if (tick16) begin
            if (rxCnt == MID) begin
              rxCnt <= '0;
              if (rxLine) rxPh <= PH_IDLE;
              else begin
                rxPh <= PH_DATA;
                rxIdx <= '0;
              end
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick16) begin
            if (rxCnt != LAST) rxCnt <= rxCnt + 1'b1;
            else begin
              rxCnt <= '0;
              case (rxPh)
                PH_DATA: begin
                  if (rxIdx == lastIdx) rxPh <= parityEn ? PH_PARITY : PH_STOP;
                  else rxIdx <= rxIdx + 1'b1;
                end
                PH_PARITY: rxPh <= PH_STOP;
                default:   rxPh <= (rxAllZero && !rxLine) ? PH_WAITHI : PH_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.txLoad       = (txPh == PH_IDLE) && thrFull;
    strobes.txBusy       = (txPh != PH_IDLE);
    strobes.txPhase      = txPh;
    strobes.txBitIdx     = txIdx;
    strobes.rxClear      = (rxPh == PH_IDLE) && tick16 && !rxLine;
    strobes.rxDataSample = (rxPh == PH_DATA) && rxBitEnd;
    strobes.rxBitIdx     = rxIdx;
    strobes.rxParSample  = (rxPh == PH_PARITY) && rxBitEnd;
    strobes.rxStopSample = (rxPh == PH_STOP) && rxBitEnd;
    strobes.rxBreak      = (rxPh == PH_STOP) && rxBitEnd && rxAllZero && !rxLine;
  end

  // R1: data sampling never goes past the selected word length
  p_rx_idx_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxDataSample |-> (rxIdx <= lastIdx));

  // R6: a load always starts a busy transmitter on the next cycle
  p_load_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> (strobes.txBusy && txPh == PH_START));

  // R4: the transmitter leaves the stop phase only at a bit boundary
  p_stop_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txPh == PH_STOP && !txBitEnd) |=> (txPh == PH_STOP));
endmodule

// File: rtl/uart_char_dp.sv
module uart_char_dp
  import uart_char_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [1:0]          wordLen,
  input  logic                parityEn,
  input  logic                evenSel,
  input  logic                stickPar,
  input  logic                breakCtl,
  input  logic                loopEn,
  input  logic [MAX_DATA-1:0] txData,
  input  logic                txWrite,
  input  logic                rxRead,
  input  logic                statRead,
  input  logic                serIn,
  output logic                serOut,
  output logic                rxLine,
  output logic                rxAllZero,
  output logic                thrFull,
  output logic [MAX_DATA-1:0] rxData,
  output logic                dataReady,
  output logic                thrEmpty,
  output logic                txEmpty,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                frameErr,
  output logic                breakInt
);
  logic [MAX_DATA-1:0] thrReg, txShift, rxBuf, rxHold;
  logic                rxParBit;
  logic                txLine, txWire, rxRaw;
  logic [SYNC_STAGES-1:0] syncQ;

  // transmit holding and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg <= '0;
      thrFull <= 1'b0;
      txShift <= '0;
    end else if (strobes.txLoad) begin
      txShift <= thrReg;
      thrFull <= 1'b0;
    end else if (txWrite && !thrFull) begin
      thrReg <= txData;
      thrFull <= 1'b1;
    end
  end

  always_comb begin
    case (strobes.txPhase)
      PH_START:  txLine = 1'b0;
      PH_DATA:   txLine = txShift[strobes.txBitIdx];
      PH_PARITY: txLine = parityOf(txShift, wordLen, evenSel, stickPar);
      default:   txLine = 1'b1;
    endcase
  end

  assign txWire   = txLine & ~breakCtl;
  assign serOut   = loopEn ? 1'b1 : txWire;
  assign rxRaw    = loopEn ? txWire : serIn;
  assign thrEmpty = ~thrFull;
  assign txEmpty  = ~thrFull & ~strobes.txBusy;

  // receive line synchroniser, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else begin
      syncQ[0] <= rxRaw;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign rxLine = syncQ[SYNC_STAGES-1];

  // receive shift state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
      rxAllZero <= 1'b1;
      rxParBit <= 1'b0;
    end else if (strobes.rxClear) begin
      rxBuf <= '0;
      rxAllZero <= 1'b1;
      rxParBit <= 1'b0;
    end else if (strobes.rxDataSample) begin
      rxBuf[strobes.rxBitIdx] <= rxLine;
      if (rxLine) rxAllZero <= 1'b0;
    end else if (strobes.rxParSample) begin
      rxParBit <= rxLine;
      if (rxLine) rxAllZero <= 1'b0;
    end
  end

  // receive holding register and sticky status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold <= '0;
      dataReady <= 1'b0;
      overrunErr <= 1'b0;
      parityErr <= 1'b0;
      frameErr <= 1'b0;
      breakInt <= 1'b0;
    end else begin
      if (statRead) begin
        overrunErr <= 1'b0;
        parityErr <= 1'b0;
        frameErr <= 1'b0;
        breakInt <= 1'b0;
      end
      if (rxRead) dataReady <= 1'b0;
      if (strobes.rxStopSample) begin
        if (strobes.rxBreak) begin
          breakInt <= 1'b1;
        end else begin
          if (!rxLine) frameErr <= 1'b1;
          if (parityEn && (rxParBit != parityOf(rxBuf, wordLen, evenSel, stickPar)))
            parityErr <= 1'b1;
          if (dataReady && !rxRead) overrunErr <= 1'b1;
          else begin
            rxHold <= rxBuf;
            dataReady <= 1'b1;
          end
        end
      end
    end
  end
  assign rxData = rxHold;

  // R6: a write that finds the holding register full leaves it untouched
  p_thr_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (thrFull && !strobes.txLoad) |=> ($stable(thrReg) && thrFull));

  // R8: a character completing into an unread register is dropped
  p_overrun_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxStopSample && !strobes.rxBreak && dataReady && !rxRead)
      |=> ($stable(rxHold) && overrunErr && dataReady));

  // R9: status read with no completing character clears every flag
  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !strobes.rxStopSample)
      |=> (!overrunErr && !parityErr && !frameErr && !breakInt));

  // R10: a break raises its own flag and not the framing flag
  p_break_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxBreak && !frameErr) |=> (breakInt && !frameErr && $stable(rxHold)));
endmodule

// File: rtl/uart_char_core.sv
module uart_char_core
  import uart_char_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [1:0] wordLen,
  input  logic       twoStop,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickPar,
  input  logic       breakCtl,
  input  logic       loopEn,
  input  logic [7:0] txData,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       statRead,
  input  logic       serIn,
  output logic       serOut,
  output logic [7:0] rxData,
  output logic       dataReady,
  output logic       thrEmpty,
  output logic       txEmpty,
  output logic       overrunErr,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakInt
);
  strobes_t strobes;
  logic     thrFull, rxLine, rxAllZero;

  uart_char_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .wordLen(wordLen),
    .twoStop(twoStop), .parityEn(parityEn), .thrFull(thrFull),
    .rxLine(rxLine), .rxAllZero(rxAllZero), .strobes(strobes)
  );

  uart_char_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordLen(wordLen),
    .parityEn(parityEn), .evenSel(evenSel), .stickPar(stickPar),
    .breakCtl(breakCtl), .loopEn(loopEn), .txData(txData),
    .txWrite(txWrite), .rxRead(rxRead), .statRead(statRead),
    .serIn(serIn), .serOut(serOut), .rxLine(rxLine),
    .rxAllZero(rxAllZero), .thrFull(thrFull), .rxData(rxData),
    .dataReady(dataReady), .thrEmpty(thrEmpty), .txEmpty(txEmpty),
    .overrunErr(overrunErr), .parityErr(parityErr),
    .frameErr(frameErr), .breakInt(breakInt)
  );
endmodule

// File: tb/uart_char_core_tb_top.sv
`timescale 1ns/1ps
module uart_char_core_tb_top;
  localparam int TDIV   = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic twoStop = 1'b0, parityEn = 1'b0, evenSel = 1'b0, stickPar = 1'b0;
  logic breakCtl = 1'b0, loopEn = 1'b0;
  logic [7:0] txData = 8'h00;
  logic txWrite = 1'b0, rxRead = 1'b0, statRead = 1'b0, serIn = 1'b1;
  logic serOut, dataReady, thrEmpty, txEmpty, overrunErr, parityErr, frameErr, breakInt;
  logic [7:0] rxData;

  always #2.5 clk = ~clk;

  int divCnt = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    divCnt <= (divCnt == TDIV - 1) ? 0 : divCnt + 1;
    tick16 <= (divCnt == TDIV - 1);
  end

  uart_char_core dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .wordLen(wordLen),
    .twoStop(twoStop), .parityEn(parityEn), .evenSel(evenSel),
    .stickPar(stickPar), .breakCtl(breakCtl), .loopEn(loopEn),
    .txData(txData), .txWrite(txWrite), .rxRead(rxRead),
    .statRead(statRead), .serIn(serIn), .serOut(serOut),
    .rxData(rxData), .dataReady(dataReady), .thrEmpty(thrEmpty),
    .txEmpty(txEmpty), .overrunErr(overrunErr), .parityErr(parityErr),
    .frameErr(frameErr), .breakInt(breakInt)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    string      req;
  } exp_t;
  exp_t sb[$];
  bit monOn = 1'b1;

  // monitor: pops the scoreboard whenever a character is presented
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && dataReady) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected character", int'(rxData), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rxData == e.d, e.req, "received data", int'(rxData), int'(e.d));
          check(parityErr == e.pe, e.req, "parity flag", int'(parityErr), int'(e.pe));
          check(frameErr == e.fe, e.req, "frame flag", int'(frameErr), int'(e.fe));
        end
        rxRead = 1'b1;
        statRead = 1'b1;
        @(negedge clk);
        rxRead = 1'b0;
        statRead = 1'b0;
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] maskOf(input int nb);
    return 8'(('h1 << nb) - 1);
  endfunction

  function automatic logic expPar(input logic [7:0] d, input int nb,
                                  input logic even, input logic stick);
    logic p;
    if (stick) return ~even;
    p = ^(d & maskOf(nb));
    return even ? p : ~p;
  endfunction

  task automatic setCfg(input int nb, input bit pen, input bit even,
                        input bit stick, input bit two);
    @(negedge clk);
    wordLen = 2'(nb - 5);
    parityEn = pen;
    evenSel = even;
    stickPar = stick;
    twoStop = two;
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit hasPar,
                           input logic parBit, input logic stopBit);
    @(negedge clk);
    serIn = 1'b0;
    waitClk(BITCLK);
    for (int i = 0; i < nb; i++) begin
      serIn = d[i];
      waitClk(BITCLK);
    end
    if (hasPar) begin
      serIn = parBit;
      waitClk(BITCLK);
    end
    serIn = stopBit;
    waitClk(BITCLK);
    serIn = 1'b1;
    waitClk(BITCLK);
  endtask

  task automatic expectRx(input logic [7:0] d, input int nb, input logic pe,
                          input logic fe, input string req);
    exp_t e;
    e.d = d & maskOf(nb);
    e.pe = pe;
    e.fe = fe;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (sb.size() != 0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    waitClk(4);
    check(sb.size() == 0, req, "scoreboard drained", sb.size(), 0);
  endtask

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk);
    txData = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic captureFrame(input int nb, input bit hasPar, output logic [7:0] d,
                              output logic p, output logic st, output int tStart);
    int guard = 0;
    while (serOut !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    tStart = cyc;
    waitClk(BITCLK / 2);
    d = '0;
    for (int i = 0; i < nb; i++) begin
      waitClk(BITCLK);
      d[i] = serOut;
    end
    p = 1'b0;
    if (hasPar) begin
      waitClk(BITCLK);
      p = serOut;
    end
    waitClk(BITCLK);
    st = serOut;
  endtask

  task automatic waitTxIdle();
    int guard = 0;
    while (!txEmpty && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    waitClk(BITCLK);
  endtask

  task automatic txCase(input logic [7:0] d, input int nb, input bit pen,
                        input bit even, input bit stick, input string req);
    logic [7:0] got;
    logic p, st;
    int t0;
    setCfg(nb, pen, even, stick, 1'b0);
    writeTx(d);
    captureFrame(nb, pen, got, p, st, t0);
    check(got == (d & maskOf(nb)), req, "tx data", int'(got), int'(d & maskOf(nb)));
    if (pen) check(p == expPar(d, nb, even, stick), req, "tx parity", int'(p),
                   int'(expPar(d, nb, even, stick)));
    check(st == 1'b1, req, "tx stop", int'(st), 1);
    waitTxIdle();
  endtask

  initial begin
    logic [7:0] g1, g2;
    logic p1, s1, p2, s2;
    int tA, tB;
    bit allHigh;

    waitClk(5);
    // reset state
    check(serOut == 1'b1, "R5", "reset serOut", int'(serOut), 1);
    check(thrEmpty && txEmpty, "R6", "reset empty flags", int'({thrEmpty, txEmpty}), 3);
    check(!dataReady, "R7", "reset dataReady", int'(dataReady), 0);
    check({overrunErr, parityErr, frameErr, breakInt} == 4'b0, "R9", "reset flags",
          int'({overrunErr, parityErr, frameErr, breakInt}), 0);
    rstN = 1'b1;
    waitClk(5);

    // R1, R2: receive 8-bit, even and odd parity
    setCfg(8, 1, 1, 0, 0);
    expectRx(8'hA5, 8, 0, 0, "R2");
    sendFrame(8'hA5, 8, 1, expPar(8'hA5, 8, 1, 0), 1'b1);
    expectRx(8'h3D, 8, 0, 0, "R2");
    sendFrame(8'h3D, 8, 1, expPar(8'h3D, 8, 1, 0), 1'b1);
    setCfg(8, 1, 0, 0, 0);
    expectRx(8'h5A, 8, 0, 0, "R2");
    sendFrame(8'h5A, 8, 1, expPar(8'h5A, 8, 0, 0), 1'b1);
    expectRx(8'h5B, 8, 1, 0, "R9");
    sendFrame(8'h5B, 8, 1, ~expPar(8'h5B, 8, 0, 0), 1'b1);
    drain("R2");

    // R1: each word length, upper bits set in the source byte
    for (int nb = 5; nb <= 8; nb++) begin
      setCfg(nb, 0, 0, 0, 0);
      expectRx(8'hF6, nb, 0, 0, "R1");
      sendFrame(8'hF6, nb, 0, 1'b0, 1'b1);
    end
    setCfg(5, 1, 1, 0, 0);
    expectRx(8'hEB, 5, 0, 0, "R1");
    sendFrame(8'hEB, 5, 1, expPar(8'hEB, 5, 1, 0), 1'b1);
    drain("R1");

    // R3: stick parity receive, both constants, right and wrong
    setCfg(7, 1, 1, 1, 0);
    expectRx(8'h07, 7, 0, 0, "R3");
    sendFrame(8'h07, 7, 1, 1'b0, 1'b1);
    expectRx(8'h07, 7, 1, 0, "R3");
    sendFrame(8'h07, 7, 1, 1'b1, 1'b1);
    setCfg(7, 1, 0, 1, 0);
    expectRx(8'h06, 7, 0, 0, "R3");
    sendFrame(8'h06, 7, 1, 1'b1, 1'b1);
    expectRx(8'h06, 7, 1, 0, "R3");
    sendFrame(8'h06, 7, 1, 1'b0, 1'b1);
    drain("R3");

    // R9: framing error keeps the character; R4 receiver needs only one stop
    setCfg(8, 0, 0, 0, 1);
    expectRx(8'h41, 8, 0, 1, "R9");
    sendFrame(8'h41, 8, 0, 1'b0, 1'b0);
    expectRx(8'h42, 8, 0, 0, "R4");
    sendFrame(8'h42, 8, 0, 1'b0, 1'b1);
    drain("R9");

    // R8: overrun
    monOn = 1'b0;
    setCfg(8, 0, 0, 0, 0);
    sendFrame(8'h11, 8, 0, 1'b0, 1'b1);
    sendFrame(8'h22, 8, 0, 1'b0, 1'b1);
    check(dataReady == 1'b1, "R8", "dataReady held", int'(dataReady), 1);
    check(rxData == 8'h11, "R8", "older char kept", int'(rxData), 'h11);
    check(overrunErr == 1'b1, "R8", "overrun flag", int'(overrunErr), 1);
    @(negedge clk);
    rxRead = 1'b1;
    statRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
    statRead = 1'b0;
    check(!dataReady && !overrunErr, "R7", "read clears", int'({dataReady, overrunErr}), 0);

    // R10: received break
    @(negedge clk);
    serIn = 1'b0;
    waitClk(12 * BITCLK);
    serIn = 1'b1;
    waitClk(2 * BITCLK);
    check(breakInt == 1'b1, "R10", "break flag", int'(breakInt), 1);
    check(frameErr == 1'b0, "R10", "no frame flag on break", int'(frameErr), 0);
    check(dataReady == 1'b0, "R10", "no char on break", int'(dataReady), 0);
    @(negedge clk);
    statRead = 1'b1;
    @(negedge clk);
    statRead = 1'b0;
    check(breakInt == 1'b0, "R9", "status read clears break", int'(breakInt), 0);
    monOn = 1'b1;
    expectRx(8'hC8, 8, 0, 0, "R10");
    sendFrame(8'hC8, 8, 0, 1'b0, 1'b1);
    drain("R10");

    // R11: short low pulse
    @(negedge clk);
    serIn = 1'b0;
    waitClk(5 * TDIV);
    serIn = 1'b1;
    waitClk(12 * BITCLK);
    check(!dataReady && {parityErr, frameErr, breakInt} == 3'b0, "R11",
          "glitch ignored", int'({dataReady, parityErr, frameErr, breakInt}), 0);
    expectRx(8'h9E, 8, 0, 0, "R11");
    sendFrame(8'h9E, 8, 0, 1'b0, 1'b1);
    drain("R11");

    // transmit frames: R1, R2, R3
    txCase(8'hC7, 8, 1, 1, 0, "R2");
    txCase(8'hC3, 8, 1, 0, 0, "R2");
    txCase(8'hF5, 5, 1, 0, 0, "R1");
    txCase(8'h6A, 6, 0, 0, 0, "R1");
    txCase(8'h33, 7, 1, 0, 1, "R3");
    txCase(8'h33, 7, 1, 1, 1, "R3");

    // R6: empty flags, ignored write, one-stop spacing
    setCfg(8, 0, 0, 0, 0);
    writeTx(8'hA1);
    check(thrEmpty == 1'b0 && txEmpty == 1'b0, "R6", "holding full",
          int'({thrEmpty, txEmpty}), 0);
    waitClk(1);
    check(thrEmpty == 1'b1 && txEmpty == 1'b0, "R6", "moved to shifter",
          int'({thrEmpty, txEmpty}), 2);
    writeTx(8'hB2);
    writeTx(8'hC3);
    captureFrame(8, 0, g1, p1, s1, tA);
    captureFrame(8, 0, g2, p2, s2, tB);
    check(g1 == 8'hA1 && g2 == 8'hB2, "R6", "frames A then B", int'({g1, g2}), 'hA1B2);
    check((tB - tA) >= 626 && (tB - tA) <= 650, "R4", "one stop spacing", tB - tA, 640);
    waitClk(BITCLK);
    allHigh = 1'b1;
    for (int i = 0; i < 16; i++) begin
      waitClk(BITCLK);
      if (serOut !== 1'b1) allHigh = 1'b0;
    end
    check(allHigh, "R6", "write while full ignored", int'(allHigh), 1);
    check(thrEmpty && txEmpty, "R6", "both empty at end", int'({thrEmpty, txEmpty}), 3);

    // R4: two stop bits
    setCfg(8, 0, 0, 0, 1);
    writeTx(8'h55);
    writeTx(8'hAA);
    captureFrame(8, 0, g1, p1, s1, tA);
    captureFrame(8, 0, g2, p2, s2, tB);
    check(g1 == 8'h55 && g2 == 8'hAA, "R4", "two-stop frames", int'({g1, g2}), 'h55AA);
    check((tB - tA) >= 690 && (tB - tA) <= 715, "R4", "two stop spacing", tB - tA, 704);
    waitTxIdle();

    // R5: transmit break
    setCfg(8, 0, 0, 0, 0);
    @(negedge clk);
    breakCtl = 1'b1;
    waitClk(3);
    check(serOut == 1'b0, "R5", "break low", int'(serOut), 0);
    waitClk(3 * BITCLK);
    check(serOut == 1'b0, "R5", "break still low", int'(serOut), 0);
    breakCtl = 1'b0;
    waitClk(2);
    check(serOut == 1'b1, "R5", "break released", int'(serOut), 1);
    waitClk(2 * BITCLK);

    // R12: loopback with serIn held low
    @(negedge clk);
    serIn = 1'b0;
    loopEn = 1'b1;
    waitClk(4);
    expectRx(8'h96, 8, 0, 0, "R12");
    writeTx(8'h96);
    allHigh = 1'b1;
    for (int i = 0; i < 11; i++) begin
      waitClk(BITCLK);
      if (serOut !== 1'b1) allHigh = 1'b0;
    end
    check(allHigh, "R12", "serOut idle in loopback", int'(allHigh), 1);
    drain("R12");
    @(negedge clk);
    serIn = 1'b1;
    waitClk(4);
    loopEn = 1'b0;
    waitClk(BITCLK);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule